// File: doc/BRIEF.md
# Sticky Alarm Interrupt Controller

This block collects eight alarm lines from a clocking subsystem: two lock-loss alarms, two holdover alarms and four reference-loss alarms. Each alarm line passes through a synchronizer. While a synchronized alarm is active, it sets a sticky flag. A flag stays set until software writes a 1 to its bit, and that clear takes effect only when the alarm has already gone inactive.

Each flag has an enable bit. The OR of all enabled flags drives a registered device interrupt status bit. The same OR drives a registered line-drive enable, `irq_oe`. When `irq_oe` is 1, the pad outside the block pulls a shared active-low interrupt line low. When it is 0, the pad releases the line.

A small register port gives software access to the block:
- It reads the flags, with write-one-to-clear.
- It reads and writes the enables.
- It reads the summary bit.

Read data is registered.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: The flag vector is ordered as follows: bits 1:0 are the lock-loss alarms `lol_i[1:0]`, bits 3:2 are the holdover alarms `hold_i[1:0]`, and bits 7:4 are the reference-loss alarms `los_i[3:0]`. An alarm passes through two synchronizer stages. If it is active before a rising edge, its flag is set on the third rising edge counted from that edge, including that edge. This also holds for a one-cycle alarm pulse.
- R2: A write to address 0 with data bit i set clears flag i on that edge, provided the synchronized alarm i is inactive.
- R3: If synchronized alarm i is active in the same cycle as a clear write, flag i stays set. Setting wins over clearing.
- R4: Address 1 is the enable register. It is read/write, one bit per flag in the R1 order, and resets to 0.
- R5: `irq_status` is 1 exactly one cycle after any flag is set whose enable bit is 1. Reading address 2 returns `irq_status` in bit 0 and 0 in the other bits.
- R6: `irq_oe` (1 = pull the active-low interrupt line low, 0 = release the line) always equals `irq_status`.
- R7: A set flag whose enable bit is 0 stays readable at address 0 and does not assert `irq_status` or `irq_oe`.
- R8: When `rst` is high on a rising edge, all flags, enables, synchronizer stages, `reg_rdata`, `irq_status` and `irq_oe` clear to 0.
- R9: `reg_rdata` holds the content of the register at `reg_addr` as sampled on the previous rising edge. Address 3 reads 0. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lol_i | input | 2 | Lock-loss alarms, asynchronous |
| hold_i | input | 2 | Holdover alarms, asynchronous |
| los_i | input | 4 | Reference-loss alarms, asynchronous |
| reg_addr | input | 2 | Register address: 0 flags, 1 enables, 2 status, 3 unused |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_status | output | 1 | Device interrupt status |
| irq_oe | output | 1 | Drive enable for the active-low open-drain interrupt line |

## Verification
An alarm shows in a flag three edges after it is applied. It reaches `irq_status` and `irq_oe` on the fourth edge. A flag shows in `reg_rdata` one edge after the flag changes. Enable writes and clear writes act on the edge that samples them. Their effect on the interrupt comes one edge later.

The bench keeps a cycle model of these register stages, advanced on every rising edge. Inputs are driven on falling edges, and all outputs are compared on falling edges, half a period after the results are due. Directed reads use the same one-edge read latency.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_FLAGS  = 2'd0,
    RA_ENABLE = 2'd1,
    RA_STATUS = 2'd2,
    RA_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] alarm_s,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] flag_q
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flag_q[i] <= 1'b0;
      else if (alarm_s[i]) flag_q[i] <= 1'b1;
      else if (clr_mask[i]) flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/enable_reg.sv
module enable_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (wr_en) en_q <= wdata;
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flag_q,
  input  logic [W-1:0] en_q,
  output logic         status_q,
  output logic         oe_q
);
  logic any_pending;
  assign any_pending = |(flag_q & en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      status_q <= any_pending;
      oe_q     <= any_pending;
    end
  end
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int unsigned N_LOL      = 2,
  parameter int unsigned N_HOLD     = 2,
  parameter int unsigned N_LOS      = 4,
  parameter int unsigned SYNC_DEPTH = 2,
  localparam int unsigned N_SRC     = N_LOL + N_HOLD + N_LOS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_LOL-1:0]  lol_i,
  input  logic [N_HOLD-1:0] hold_i,
  input  logic [N_LOS-1:0]  los_i,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [N_SRC-1:0]  reg_wdata,
  output logic [N_SRC-1:0]  reg_rdata,
  output logic              irq_status,
  output logic              irq_oe
);
  logic [N_SRC-1:0] alarm_raw;
  logic [N_SRC-1:0] alarm_sync_v;
  logic [N_SRC-1:0] flags;
  logic [N_SRC-1:0] enables;
  logic [N_SRC-1:0] clr_mask;
  logic             wr_enable;
  reg_addr_e        addr_dec;

  assign alarm_raw = {los_i, hold_i, lol_i};
  assign addr_dec  = reg_addr_e'(reg_addr);
  assign clr_mask  = (reg_wr && addr_dec == RA_FLAGS) ? reg_wdata : '0;
  assign wr_enable = reg_wr && addr_dec == RA_ENABLE;

  alarm_sync #(.W(N_SRC), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .din(alarm_raw), .dout(alarm_sync_v)
  );

  flag_bank #(.W(N_SRC)) u_flags (
    .clk(clk), .rst(rst), .alarm_s(alarm_sync_v), .clr_mask(clr_mask), .flag_q(flags)
  );

  enable_reg #(.W(N_SRC)) u_enable (
    .clk(clk), .rst(rst), .wr_en(wr_enable), .wdata(reg_wdata), .en_q(enables)
  );

  irq_combine #(.W(N_SRC)) u_irq (
    .clk(clk), .rst(rst), .flag_q(flags), .en_q(enables),
    .status_q(irq_status), .oe_q(irq_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (addr_dec)
        RA_FLAGS:  reg_rdata <= flags;
        RA_ENABLE: reg_rdata <= enables;
        RA_STATUS: reg_rdata <= {{(N_SRC-1){1'b0}}, irq_status};
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] alarm_s,
  input logic [W-1:0] flag_q,
  input logic [W-1:0] en_q,
  input logic [W-1:0] clr_mask,
  input logic         irq_status,
  input logic         irq_oe
);
  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((flag_q & $past(alarm_s)) == $past(alarm_s)));

  // R2
  fall_needs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((($past(flag_q) & ~flag_q) & ~$past(clr_mask))) == '0));

  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(flag_q & en_q)) |=> irq_status);

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_q & en_q)) |=> !irq_status);

  // R6
  oe_match_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |-> (irq_oe == irq_status));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flag_q == '0 && en_q == '0 && !irq_status && !irq_oe));
endmodule

bind alarm_irq_ctrl alarm_irq_chk #(.W(N_SRC)) chk_i (
  .clk(clk), .rst(rst), .alarm_s(alarm_sync_v), .flag_q(flags), .en_q(enables),
  .clr_mask(clr_mask), .irq_status(irq_status), .irq_oe(irq_oe)
);

// File: tb/alarm_irq_ctrl_tb_top.sv
module alarm_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] lol = '0;
  logic [1:0] hold = '0;
  logic [3:0] los = '0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_status;
  logic       irq_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit started = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .lol_i(lol), .hold_i(hold), .los_i(los),
    .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata),
    .irq_status(irq_status), .irq_oe(irq_oe)
  );

  // Cycle model built from the requirements
  logic [7:0] m_s1 = '0, m_s2 = '0, m_flag = '0, m_en = '0, m_rd = '0;
  logic       m_irq = 1'b0;

  function automatic logic [7:0] read_exp(logic [1:0] a, logic [7:0] f, logic [7:0] e, logic q);
    case (a)
      2'd0: return f;
      2'd1: return e;
      2'd2: return {7'b0, q};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [7:0] clr, nflag, nen, nrd;
    logic nirq;
    started = 1;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_flag = '0; m_en = '0; m_rd = '0; m_irq = 0;
    end else begin
      nrd   = read_exp(addr, m_flag, m_en, m_irq);
      clr   = (wr && addr == 2'd0) ? wdata : 8'h00;
      nflag = m_s2 | (m_flag & ~clr);
      nen   = (wr && addr == 2'd1) ? wdata : m_en;
      nirq  = |(m_flag & m_en);
      m_s2 = m_s1; m_s1 = {los, hold, lol};
      m_flag = nflag; m_en = nen; m_rd = nrd; m_irq = nirq;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  logic [1:0] rd_addr_q = '0;
  always @(posedge clk) rd_addr_q <= addr;

  always @(negedge clk) begin
    if (started && !done) begin
      check("R5", {7'b0, irq_status}, {7'b0, m_irq});
      check("R6", {7'b0, irq_oe}, {7'b0, m_irq});
      case (rd_addr_q)
        2'd0: check("R1 R2 R3 flag read", rdata, m_rd);
        2'd1: check("R4", rdata, m_rd);
        2'd2: check("R5 status read", rdata, m_rd);
        default: check("R9", rdata, m_rd);
      endcase
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr = 0;
    end
  endtask

  task automatic write_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wr = 1; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic read_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; wr = 0;
    @(negedge clk); d = rdata;
  endtask

  task automatic set_alarms(logic [7:0] v);
    {los, hold, lol} = v;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2718));
    idle(3);
    @(negedge clk); rst = 0;
    // R8 reset state
    read_reg(2'd0, v); check("R8 flags after reset", v, 8'h00);
    read_reg(2'd1, v); check("R8 enables after reset", v, 8'h00);
    check("R8 irq_oe after reset", {7'b0, irq_oe}, 8'h00);

    // R1: reference-loss alarm 1 lands in flag bit 5; R7: not enabled
    @(negedge clk); set_alarms(8'h20);
    idle(4);
    read_reg(2'd0, v); check("R1 los1 flag", v, 8'h20);
    check("R7 disabled flag no irq", {7'b0, irq_status}, 8'h00);

    // R3: clear while alarm active is ignored
    write_reg(2'd0, 8'h20);
    read_reg(2'd0, v); check("R3 clear blocked", v, 8'h20);

    // R2: alarm gone, clear succeeds
    @(negedge clk); set_alarms(8'h00);
    idle(3);
    write_reg(2'd0, 8'h20);
    read_reg(2'd0, v); check("R2 clear applied", v, 8'h00);

    // R4/R5/R6
    write_reg(2'd1, 8'hFF);
    read_reg(2'd1, v); check("R4 enable readback", v, 8'hFF);
    @(negedge clk); set_alarms(8'h01);
    idle(5);
    check("R5 irq on enabled flag", {7'b0, irq_status}, 8'h01);
    check("R6 line pulled", {7'b0, irq_oe}, 8'h01);
    read_reg(2'd2, v); check("R5 status register", v, 8'h01);

    // R9: writes to 2 and 3 have no effect; 3 reads zero
    write_reg(2'd3, 8'h00);
    write_reg(2'd2, 8'h00);
    read_reg(2'd1, v); check("R9 enables untouched", v, 8'hFF);
    read_reg(2'd3, v); check("R9 spare reads zero", v, 8'h00);

    // R1: one-cycle pulse on holdover 1 (bit 3) still latches
    @(negedge clk); set_alarms(8'h08);
    @(negedge clk); set_alarms(8'h00);
    idle(4);
    read_reg(2'd0, v); check("R1 pulse latched", v, 8'h09);

    // Random phase
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) set_alarms(8'($urandom) & 8'($urandom));
      addr  = 2'($urandom);
      wr    = ($urandom_range(0, 3) == 0);
      wdata = 8'($urandom);
      if (c == 2500) rst = 1;
      if (c == 2503) rst = 0;
    end

    // R8 mid-run reset
    @(negedge clk); rst = 1; wr = 0; set_alarms(8'h00);
    @(negedge clk); rst = 0;
    read_reg(2'd1, v); check("R8 enables cleared", v, 8'h00);
    read_reg(2'd0, v); check("R8 flags cleared", v, 8'h00);
    idle(2);
    finish_run();
  end
endmodule